// File: doc/BRIEF.md
# UART FIFO Channel-Mode Router

This block sits between the serial receiver and transmitter of a UART and the host's data register. It holds one receive FIFO and one transmit FIFO. A two-bit channel mode decides where bytes go. Bytes from the serial receiver can go to the receive FIFO, the transmit FIFO, or both. Host writes to the data register can go to the transmit FIFO or the receive FIFO, or they are dropped. The transmit FIFO feeds the serial transmitter through a valid/ready handshake. Host reads of the data register pop the oldest received byte.

A small control register gates each path with an enable bit and a disable bit, and has two self-clearing bits that empty the FIFOs. The block presents both FIFO fill levels and one-cycle overflow pulses to the interrupt logic beside it. A break condition detected on the line is entered as a zero byte. Bit timing and baud generation live elsewhere.

Top module: `uart_chan_router`

## Requirements
- R1: The mode register at offset 0x04 holds the channel mode in bits 9:8: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. A read of offset 0x04 returns the mode in bits 9:8 and zero elsewhere. It resets to normal.
- R2: A serial byte accepted by the handshake is routed by mode. It goes to the RX FIFO in normal mode, to both FIFOs in echo mode, and to the TX FIFO in remote loopback. In local loopback it is accepted and dropped.
- R3: A host write to the data register (offset 0x30, byte in bits 7:0) is routed by mode. It goes to the TX FIFO in normal mode and to the RX FIFO in local loopback. In echo and remote loopback it is discarded.
- R4: `ser_rx_ready` is low while `ser_brk` is high. It is also low while any FIFO that the current mode routes serial bytes into is full. Otherwise it is high. A serial handshake therefore never overruns a FIFO.
- R5: The control register is at offset 0x00. The RX path is enabled when bit 2 is 1 and bit 3 is 0. The TX path is enabled when bit 4 is 1 and bit 5 is 0. A push into a disabled path is dropped.
- R6: A push into a full FIFO drops the byte and leaves the count at the depth. In the cycle after the push, the FIFO's overflow pulse is high (`rx_ovr_pulse` or `tx_ovf_pulse`). A push into a FIFO that is not full raises no pulse.
- R7: A host read of offset 0x30 returns the oldest RX byte in bits 7:0 and pops it. It returns 0 when the FIFO is empty. It returns 0 and does not pop while the RX path is disabled. `host_rdata` is valid in the cycle after the read strobe.
- R8: Writing control bit 0 empties the RX FIFO, and writing bit 1 empties the TX FIFO. These bits read back as 0. The flush wins over a push in the same cycle.
- R9: In normal and echo mode, a `ser_brk` pulse with the RX path enabled enters 0x00 into the RX FIFO. In the other modes a break has no effect on the FIFOs.
- R10: After reset, the control register reads 0x128, which leaves both paths disabled. Both counts are 0 and `ser_tx_valid` is low.
- R11: A push and a pop on the same FIFO in the same cycle both take effect and leave the count unchanged.
- R12: `ser_tx_valid` is high only while the TX path is enabled and the TX FIFO is not empty. `ser_tx_data` is the oldest TX byte. Each cycle with valid and ready both high pops one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data, valid the cycle after `host_rd` |
| ser_rx_valid | input | 1 | Serial receiver has a byte |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_ready | output | 1 | Block can take a serial byte |
| ser_brk | input | 1 | Break condition pulse from the receiver |
| ser_tx_valid | output | 1 | TX byte available for the transmitter |
| ser_tx_data | output | 8 | Oldest TX byte |
| ser_tx_ready | input | 1 | Transmitter takes the byte |
| rx_count | output | 7 | RX FIFO fill level |
| tx_count | output | 7 | TX FIFO fill level |
| rx_ovr_pulse | output | 1 | RX push dropped because the FIFO was full |
| tx_ovf_pulse | output | 1 | TX push dropped because the FIFO was full |

## Verification
Two cases can fall in the same cycle: a push and a pop on one FIFO.
- On the RX side, the bench raises `ser_rx_valid` in the same cycle as a host read of the data register.
- On the TX side, it issues a host write of the data register while the transmitter holds `ser_tx_ready` high.

In each case the bench checks that the popped byte is the oldest one and that the count is unchanged. It then checks that later pops return the remaining and newly pushed bytes in order.

// File: rtl/uart_chr_pkg.sv
package uart_chr_pkg;

   typedef enum logic [1:0] {
      CHM_NORMAL = 2'd0,
      CHM_ECHO   = 2'd1,
      CHM_LOCAL  = 2'd2,
      CHM_REMOTE = 2'd3
   } chmode_e;

   localparam int unsigned CTRL_W = 9;

   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_MODE = 8'h04;
   localparam logic [7:0] OFF_DATA = 8'h30;

   localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;

   localparam int unsigned CB_RX_FLUSH = 0;
   localparam int unsigned CB_TX_FLUSH = 1;
   localparam int unsigned CB_RX_EN    = 2;
   localparam int unsigned CB_RX_DIS   = 3;
   localparam int unsigned CB_TX_EN    = 4;
   localparam int unsigned CB_TX_DIS   = 5;
   localparam int unsigned MODE_LSB    = 8;

endpackage

// File: rtl/uart_chr_fifo.sv
module uart_chr_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 8,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          ovf
);
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_chr_fifo: DEPTH must be at least 2");
   end
   if (CW < $clog2(DEPTH + 1)) begin : g_bad_cw
      $error("uart_chr_fifo: CW too narrow for DEPTH");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wpos;
   logic [PW-1:0] rpos;
   logic          do_push;
   logic          do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign ovf     = push && full && !flush;

   // read position = write position minus fill level, modulo depth
   if (POW2) begin : g_rpos_mask
      assign rpos = wpos - PW'(count);
   end else begin : g_rpos_mod
      logic [CW:0] rsum;
      assign rsum = (CW+1)'(wpos) + (CW+1)'(DEPTH) - (CW+1)'(count);
      assign rpos = (rsum >= (CW+1)'(DEPTH)) ? PW'(rsum - (CW+1)'(DEPTH))
                                             : PW'(rsum);
   end

   assign head = mem[rpos];

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wpos] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpos  <= '0;
         count <= '0;
      end else if (flush) begin
         wpos  <= '0;
         count <= '0;
      end else begin
         if (do_push) begin
            wpos <= (wpos == PW'(DEPTH - 1)) ? '0 : wpos + 1'b1;
         end
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R6
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop && !flush |=> count == CW'(DEPTH)); // R6
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == '0); // R8
   AST_PUSHPOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !full && !empty && !flush |=> $stable(count)); // R11

endmodule

// File: rtl/uart_chr_regs.sv
module uart_chr_regs
   import uart_chr_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output chmode_e           mode,
   output logic              rx_en,
   output logic              tx_en,
   output logic              rx_flush,
   output logic              tx_flush
);
   if (DW < MODE_LSB + 2) begin : g_bad_dw
      $error("uart_chr_regs: DW too narrow for the mode field");
   end
   if (AW < 8) begin : g_bad_aw
      $error("uart_chr_regs: AW too narrow for the register offsets");
   end

   logic ctrl_sel;
   logic mode_sel;

   assign ctrl_sel = wr && (addr == AW'(OFF_CTRL));
   assign mode_sel = wr && (addr == AW'(OFF_MODE));

   assign rx_flush = ctrl_sel && wdata[CB_RX_FLUSH];
   assign tx_flush = ctrl_sel && wdata[CB_TX_FLUSH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         mode   <= CHM_NORMAL;
      end else begin
         if (ctrl_sel) begin
            ctrl_q <= {wdata[CTRL_W-1:2], 2'b00};
         end
         if (mode_sel) begin
            mode <= chmode_e'(wdata[MODE_LSB +: 2]);
         end
      end
   end

   assign rx_en = ctrl_q[CB_RX_EN] && !ctrl_q[CB_RX_DIS];
   assign tx_en = ctrl_q[CB_TX_EN] && !ctrl_q[CB_TX_DIS];

   AST_EN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_sel |=> rx_en == ($past(wdata[CB_RX_EN]) && !$past(wdata[CB_RX_DIS]))); // R5

endmodule

// File: rtl/uart_chr_route.sv
module uart_chr_route
   import uart_chr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  chmode_e      mode,
   input  logic         rx_en,
   input  logic         tx_en,
   input  logic         ser_valid,
   input  logic [W-1:0] ser_data,
   input  logic         brk,
   input  logic         host_dw,
   input  logic [W-1:0] host_byte,
   input  logic         rx_full,
   input  logic         tx_full,
   output logic         ser_ready,
   output logic         rx_push,
   output logic [W-1:0] rx_byte,
   output logic         tx_push,
   output logic [W-1:0] tx_byte
);
   logic ser_to_rx;
   logic ser_to_tx;
   logic host_to_rx;
   logic host_to_tx;
   logic ser_fire;

   always_comb begin
      ser_to_rx  = 1'b0;
      ser_to_tx  = 1'b0;
      host_to_rx = 1'b0;
      host_to_tx = 1'b0;
      unique case (mode)
         CHM_NORMAL: begin
            ser_to_rx  = 1'b1;
            host_to_tx = 1'b1;
         end
         CHM_ECHO: begin
            ser_to_rx = 1'b1;
            ser_to_tx = 1'b1;
         end
         CHM_LOCAL:  host_to_rx = 1'b1;
         CHM_REMOTE: ser_to_tx  = 1'b1;
         default: ;
      endcase
   end

   assign ser_ready = !brk && !(ser_to_rx && rx_full) && !(ser_to_tx && tx_full);
   assign ser_fire  = ser_valid && ser_ready;

   assign rx_push = rx_en && ((ser_to_rx && (ser_fire || brk)) || (host_to_rx && host_dw));
   assign rx_byte = host_to_rx ? host_byte : (brk ? '0 : ser_data);

   assign tx_push = tx_en && ((ser_to_tx && ser_fire) || (host_to_tx && host_dw));
   assign tx_byte = host_to_tx ? host_byte : ser_data;

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
   import uart_chr_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned BW    = 8,
   parameter int unsigned AW    = 8,
   parameter int unsigned DW    = 32,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   input  logic          ser_rx_valid,
   input  logic [BW-1:0] ser_rx_data,
   output logic          ser_rx_ready,
   input  logic          ser_brk,
   output logic          ser_tx_valid,
   output logic [BW-1:0] ser_tx_data,
   input  logic          ser_tx_ready,
   output logic [CW-1:0] rx_count,
   output logic [CW-1:0] tx_count,
   output logic          rx_ovr_pulse,
   output logic          tx_ovf_pulse
);
   if (DW < BW || DW < CTRL_W) begin : g_bad_dw
      $error("uart_chan_router: DW narrower than a byte or control field");
   end

   logic [CTRL_W-1:0] ctrl_q;
   chmode_e           mode;
   logic              rx_en, tx_en, rx_flush, tx_flush;
   logic              host_dw, host_dr;
   logic              rx_push, tx_push, rx_pop, tx_pop;
   logic [BW-1:0]     rx_byte, tx_byte, rx_head, tx_head;
   logic              rx_full, tx_full, rx_empty, tx_empty;
   logic              rx_ovf, tx_ovf;
   logic [BW-1:0]     rd_byte;
   logic              unused_wdata;

   assign unused_wdata = ^host_wdata;

   assign host_dw = host_wr && (host_addr == AW'(OFF_DATA));
   assign host_dr = host_rd && (host_addr == AW'(OFF_DATA));

   uart_chr_regs #(.AW(AW), .DW(DW)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (host_wr),
      .addr     (host_addr),
      .wdata    (host_wdata),
      .ctrl_q   (ctrl_q),
      .mode     (mode),
      .rx_en    (rx_en),
      .tx_en    (tx_en),
      .rx_flush (rx_flush),
      .tx_flush (tx_flush)
   );

   uart_chr_route #(.W(BW)) route_i (
      .mode      (mode),
      .rx_en     (rx_en),
      .tx_en     (tx_en),
      .ser_valid (ser_rx_valid),
      .ser_data  (ser_rx_data),
      .brk       (ser_brk),
      .host_dw   (host_dw),
      .host_byte (host_wdata[BW-1:0]),
      .rx_full   (rx_full),
      .tx_full   (tx_full),
      .ser_ready (ser_rx_ready),
      .rx_push   (rx_push),
      .rx_byte   (rx_byte),
      .tx_push   (tx_push),
      .tx_byte   (tx_byte)
   );

   assign rx_pop = host_dr && rx_en;

   uart_chr_fifo #(.DEPTH(DEPTH), .W(BW), .CW(CW)) rx_fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .push      (rx_push),
      .push_data (rx_byte),
      .pop       (rx_pop),
      .head      (rx_head),
      .count     (rx_count),
      .full      (rx_full),
      .empty     (rx_empty),
      .ovf       (rx_ovf)
   );

   assign ser_tx_valid = tx_en && !tx_empty;
   assign ser_tx_data  = tx_head;
   assign tx_pop       = ser_tx_valid && ser_tx_ready;

   uart_chr_fifo #(.DEPTH(DEPTH), .W(BW), .CW(CW)) tx_fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .push      (tx_push),
      .push_data (tx_byte),
      .pop       (tx_pop),
      .head      (tx_head),
      .count     (tx_count),
      .full      (tx_full),
      .empty     (tx_empty),
      .ovf       (tx_ovf)
   );

   assign rd_byte = (rx_en && !rx_empty) ? rx_head : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata   <= '0;
         rx_ovr_pulse <= 1'b0;
         tx_ovf_pulse <= 1'b0;
      end else begin
         rx_ovr_pulse <= rx_ovf;
         tx_ovf_pulse <= tx_ovf;
         if (host_rd) begin
            if (host_addr == AW'(OFF_CTRL)) begin
               host_rdata <= DW'(ctrl_q);
            end else if (host_addr == AW'(OFF_MODE)) begin
               host_rdata <= DW'({mode, {MODE_LSB{1'b0}}});
            end else if (host_addr == AW'(OFF_DATA)) begin
               host_rdata <= DW'(rd_byte);
            end else begin
               host_rdata <= '0;
            end
         end
      end
   end

   AST_RD_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      host_dr && !rx_en && !rx_flush |=> $stable(rx_count)); // R7
   AST_SER_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      ser_rx_valid && ser_rx_ready && !host_wr |=> !rx_ovr_pulse && !tx_ovf_pulse); // R4
   AST_TXV_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ser_tx_valid |-> tx_count != '0); // R12

endmodule

// File: tb/uart_chan_router_tb_top.sv
`timescale 1ns/1ps
module uart_chan_router_tb_top;
   localparam int DEPTH = 8;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]    host_addr = '0;
   logic [31:0]   host_wdata = '0;
   logic [31:0]   host_rdata;
   logic          ser_rx_valid = 1'b0;
   logic [7:0]    ser_rx_data = '0;
   logic          ser_rx_ready;
   logic          ser_brk = 1'b0;
   logic          ser_tx_valid;
   logic [7:0]    ser_tx_data;
   logic          ser_tx_ready = 1'b0;
   logic [CW-1:0] rx_count, tx_count;
   logic          rx_ovr_pulse, tx_ovf_pulse;

   int  errors = 0;
   int  checks = 0;
   bit  done = 1'b0;
   logic [31:0] rdv;
   logic        p_rx, p_tx;
   logic [7:0]  txb;

   always #10 clk = ~clk;

   uart_chan_router #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data),
      .ser_rx_ready(ser_rx_ready), .ser_brk(ser_brk),
      .ser_tx_valid(ser_tx_valid), .ser_tx_data(ser_tx_data),
      .ser_tx_ready(ser_tx_ready),
      .rx_count(rx_count), .tx_count(tx_count),
      .rx_ovr_pulse(rx_ovr_pulse), .tx_ovf_pulse(tx_ovf_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
      p_rx = rx_ovr_pulse; p_tx = tx_ovf_pulse;
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      rdv = host_rdata;
   endtask

   task automatic ser_send(input logic [7:0] b);
      @(negedge clk);
      ser_rx_valid = 1'b1; ser_rx_data = b;
      @(negedge clk);
      ser_rx_valid = 1'b0;
   endtask

   task automatic brk_pulse(output logic rdy);
      @(negedge clk);
      ser_brk = 1'b1;
      #1 rdy = ser_rx_ready;
      @(negedge clk);
      ser_brk = 1'b0;
      p_rx = rx_ovr_pulse;
   endtask

   task automatic tx_take(output logic [7:0] b);
      @(negedge clk);
      b = ser_tx_data;
      ser_tx_ready = 1'b1;
      @(negedge clk);
      ser_tx_ready = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic rdy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 rx_count", 32'(rx_count), 0);
      chk("R10 tx_count", 32'(tx_count), 0);
      chk("R10 tx_valid", 32'(ser_tx_valid), 0);
      rd(8'h00); chk("R10 ctrl reset", rdv, 32'h128);
      rd(8'h04); chk("R1 mode reset", rdv, 0);

      // R5 disabled paths drop
      wr(8'h30, 32'h55); chk("R5 tx drop", 32'(tx_count), 0);
      ser_send(8'h11);   chk("R5 rx drop", 32'(rx_count), 0);
      rd(8'h30);         chk("R7 read disabled", rdv, 0);

      wr(8'h00, 32'h14);
      rd(8'h00); chk("R8 ctrl readback", rdv, 32'h14);

      // R3 normal: host writes fill TX; R6 overflow
      for (int i = 0; i < DEPTH; i++) begin
         wr(8'h30, 32'(i * 7 + 3));
         chk("R6 no pulse", 32'(p_tx), 0);
      end
      chk("R3 tx filled", 32'(tx_count), DEPTH);
      chk("R12 tx valid", 32'(ser_tx_valid), 1);
      wr(8'h30, 32'hEE);
      chk("R6 tx ovf pulse", 32'(p_tx), 1);
      chk("R6 tx count held", 32'(tx_count), DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         tx_take(txb);
         chk("R12 tx order", 32'(txb), 32'((i * 7 + 3) & 8'hFF));
      end
      chk("R12 tx drained", 32'(tx_count), 0);
      chk("R12 valid low", 32'(ser_tx_valid), 0);

      // R2 normal serial into RX; R4 ready when full
      for (int i = 0; i < DEPTH; i++) ser_send(8'(8'hA0 + i));
      chk("R2 rx filled", 32'(rx_count), DEPTH);
      chk("R4 ready full", 32'(ser_rx_ready), 0);
      brk_pulse(rdy);
      chk("R6 rx ovr pulse", 32'(p_rx), 1);
      chk("R6 rx count held", 32'(rx_count), DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         rd(8'h30);
         chk("R7 rx order", rdv, 32'(8'hA0 + i));
      end
      rd(8'h30); chk("R7 empty read", rdv, 0);
      chk("R7 rx empty", 32'(rx_count), 0);

      // R11 same-cycle push and pop, RX side
      ser_send(8'h31); ser_send(8'h32);
      @(negedge clk);
      ser_rx_valid = 1'b1; ser_rx_data = 8'h33;
      host_rd = 1'b1; host_addr = 8'h30;
      @(negedge clk);
      ser_rx_valid = 1'b0; host_rd = 1'b0;
      chk("R11 rx pop data", host_rdata, 32'h31);
      chk("R11 rx count", 32'(rx_count), 2);
      rd(8'h30); chk("R11 rx next", rdv, 32'h32);
      rd(8'h30); chk("R11 rx pushed", rdv, 32'h33);

      // R11 same-cycle push and pop, TX side
      wr(8'h30, 32'h41); wr(8'h30, 32'h42);
      @(negedge clk);
      host_wr = 1'b1; host_addr = 8'h30; host_wdata = 32'h43;
      ser_tx_ready = 1'b1;
      txb = ser_tx_data;
      @(negedge clk);
      host_wr = 1'b0; ser_tx_ready = 1'b0;
      chk("R11 tx pop data", 32'(txb), 32'h41);
      chk("R11 tx count", 32'(tx_count), 2);
      tx_take(txb); chk("R11 tx next", 32'(txb), 32'h42);
      tx_take(txb); chk("R11 tx pushed", 32'(txb), 32'h43);

      // R9 break in normal
      brk_pulse(rdy);
      chk("R4 ready during break", 32'(rdy), 0);
      chk("R6 break no pulse", 32'(p_rx), 0);
      chk("R9 break count", 32'(rx_count), 1);
      rd(8'h30); chk("R9 break byte", rdv, 0);

      // echo
      wr(8'h04, 32'h100);
      rd(8'h04); chk("R1 mode echo", rdv, 32'h100);
      ser_send(8'h5A);
      chk("R2 echo rx", 32'(rx_count), 1);
      chk("R2 echo tx", 32'(tx_count), 1);
      wr(8'h30, 32'h77);
      chk("R3 echo drop tx", 32'(tx_count), 1);
      chk("R3 echo drop rx", 32'(rx_count), 1);
      tx_take(txb); chk("R2 echo tx byte", 32'(txb), 32'h5A);
      rd(8'h30);    chk("R2 echo rx byte", rdv, 32'h5A);

      // R4 readiness follows TX fullness per mode
      wr(8'h04, 32'h000);
      for (int i = 0; i < DEPTH; i++) wr(8'h30, 32'(i));
      @(negedge clk); chk("R4 normal tx full", 32'(ser_rx_ready), 1);
      wr(8'h04, 32'h100); chk("R4 echo tx full", 32'(ser_rx_ready), 0);
      wr(8'h04, 32'h300); chk("R4 remote tx full", 32'(ser_rx_ready), 0);
      wr(8'h04, 32'h200); chk("R4 local", 32'(ser_rx_ready), 1);
      wr(8'h00, 32'h16);
      chk("R8 tx flush", 32'(tx_count), 0);
      rd(8'h00); chk("R8 self clear", rdv, 32'h14);

      // local loopback
      wr(8'h30, 32'h66);
      chk("R3 local rx", 32'(rx_count), 1);
      chk("R3 local tx", 32'(tx_count), 0);
      ser_send(8'h99);
      chk("R2 local ignore rx", 32'(rx_count), 1);
      chk("R2 local ignore tx", 32'(tx_count), 0);
      rd(8'h30); chk("R3 local byte", rdv, 32'h66);

      // remote loopback
      wr(8'h04, 32'h300);
      ser_send(8'h12);
      chk("R2 remote tx", 32'(tx_count), 1);
      chk("R2 remote rx", 32'(rx_count), 0);
      wr(8'h30, 32'h34);
      chk("R3 remote drop", 32'(tx_count), 1);
      brk_pulse(rdy);
      chk("R9 remote break", 32'(rx_count), 0);
      tx_take(txb); chk("R2 remote byte", 32'(txb), 32'h12);

      // R8 RX flush
      wr(8'h04, 32'h000);
      ser_send(8'h01); ser_send(8'h02); ser_send(8'h03);
      wr(8'h00, 32'h15);
      chk("R8 rx flush", 32'(rx_count), 0);
      rd(8'h00); chk("R8 rx self clear", rdv, 32'h14);

      // R7 read while RX disabled
      ser_send(8'h44);
      wr(8'h00, 32'h1C);
      rd(8'h30); chk("R7 disabled read", rdv, 0);
      chk("R7 disabled no pop", 32'(rx_count), 1);
      wr(8'h00, 32'h14);
      rd(8'h30); chk("R7 re-enabled read", rdv, 32'h44);

      // R5 / R12 TX disable holds transmitter
      wr(8'h30, 32'h21);
      wr(8'h00, 32'h24);
      chk("R5 tx disabled valid", 32'(ser_tx_valid), 0);
      chk("R5 tx kept", 32'(tx_count), 1);
      wr(8'h00, 32'h14);
      tx_take(txb); chk("R12 resumed byte", 32'(txb), 32'h21);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule